// File: doc/BRIEF.md
# Write-Protected Interrupt Register Set

This block is a small set of 32-bit control registers behind a simple single-word register bus. It holds a lock register, a control register and one interrupt group: pending status, mask, mask-clear port, mask-set port and a software trigger port. The group drives one level-sensitive interrupt line. The line is high whenever a pending bit is not masked.

The block leaves reset locked. While the lock bit is set, writes to every other register, the command ports included, change nothing. The lock register itself can always be written, so software clears the lock bit, programs the group, and may set the lock again. Reads return one cycle after the request. Unmapped offsets, misaligned offsets and accesses that are not full words read as zero, and writes to them are dropped.

Top module: `wpirq_regset`

## Requirements
- R1: After reset the lock bit reads 1, every mask bit reads 1, status and control read 0, and `irq_o` is low.
- R2: While the lock bit is 1, word writes to control (0x04), status (0x08), mask-clear (0x10), mask-set (0x14) and trigger (0x18) leave control, status and mask unchanged.
- R3: Status (0x08) is write-one-to-clear: each data bit at 1 clears that pending bit, and bits at 0 leave it unchanged.
- R4: The mask (0x0C) reads back its current value. Direct writes to it are ignored.
- R5: Writing a 1 to the mask-clear port (0x10) clears that mask bit. Writing a 1 to the mask-set port (0x14) sets it. Both ports read as 0.
- R6: Writing a 1 to the trigger port (0x18) sets that status bit. The port reads as 0.
- R7: `irq_o` is high exactly when some status bit is 1 while its mask bit is 0. It follows a register change from the clock edge that makes that change.
- R8: Only accesses with `bus_size` = 2 (word) at a 4-byte-aligned offset from 0x00 to 0x18 take effect. Any other read returns 0, and any other write changes nothing.
- R9: The lock register (0x00, bit 0) is never write-protected, and it reads back the last bit written to it.
- R10: Read data appears on `bus_rdata` after the clock edge that samples the read request, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| bus_req | input | 1 | Access request, valid for one cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | Access size code; 2 means a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ctrl_o | output | CTRL_W | Control register contents |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bound assertions check the following on every cycle. A locked write never moves status or mask. The mask changes only through the two command ports. A W1C write leaves the written bits clear, and a trigger write leaves them set. A non-word read returns zero. A lock write always lands. The reset values, the reads of the command ports and the mask, the drop of writes to unmapped offsets, and the full sequence of lock, unlock, trigger, unmask and clear on the interrupt line can only be shown by the bench's scenarios.

// File: rtl/wpirq_pkg.sv
package wpirq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  // Register index = byte offset / 4; order sets the decode.
  typedef enum logic [2:0] {
    SEL_LOCK = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_STAT = 3'd2,
    SEL_MASK = 3'd3,
    SEL_ENA  = 3'd4,
    SEL_DIS  = 3'd5,
    SEL_TRIG = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/wpirq_decode.sv
module wpirq_decode
  import wpirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output reg_sel_e          sel,
  output logic              wr_act,
  output logic              rd_act
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(SEL_TRIG);

  logic [IDX_W-1:0] idx;
  logic             mapped;

  assign idx = bus_addr[ADDR_W-1:2];

  always_comb begin
    mapped = (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00) && (idx <= MAX_IDX);
    if (mapped) begin
      sel = reg_sel_e'(idx[2:0]);
    end else begin
      sel = SEL_NONE;
    end
  end

  assign wr_act = bus_req && bus_we && (sel != SEL_NONE);
  assign rd_act = bus_req && !bus_we;
endmodule

// File: rtl/wpirq_lock.sv
module wpirq_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic lock_q
);
  logic lock_d;

  always_comb begin
    lock_d = lock_q;
    if (wr_en) begin
      lock_d = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else begin
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/wpirq_intgroup.sv
module wpirq_intgroup #(
  parameter int unsigned NUM_SRC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_clr_en,
  input  logic               stat_set_en,
  input  logic               mask_clr_en,
  input  logic               mask_set_en,
  input  logic [NUM_SRC-1:0] bits,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               irq
);
  logic [NUM_SRC-1:0] status_d;
  logic [NUM_SRC-1:0] mask_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_comb begin
      status_d[i] = status_q[i];
      if (stat_clr_en && bits[i]) begin
        status_d[i] = 1'b0;
      end else if (stat_set_en && bits[i]) begin
        status_d[i] = 1'b1;
      end
      mask_d[i] = mask_q[i];
      if (mask_clr_en && bits[i]) begin
        mask_d[i] = 1'b0;
      end else if (mask_set_en && bits[i]) begin
        mask_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
        mask_q[i]   <= 1'b1;
      end else begin
        status_q[i] <= status_d[i];
        mask_q[i]   <= mask_d[i];
      end
    end
  end

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/wpirq_regset.sv
module wpirq_regset
  import wpirq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_SRC = 1,
  parameter int unsigned CTRL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o
);
  reg_sel_e           sel;
  logic               wr_act;
  logic               rd_act;
  logic               lock_q;
  logic               wr_open;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [CTRL_W-1:0]  ctrl_d;
  logic [WORD_W-1:0]  rd_word;
  logic [WORD_W-1:0]  rdata_q;
  logic [WORD_W-1:0]  rdata_d;

  wpirq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .sel      (sel),
    .wr_act   (wr_act),
    .rd_act   (rd_act)
  );

  wpirq_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_act && (sel == SEL_LOCK)),
    .wr_bit (bus_wdata[0]),
    .lock_q (lock_q)
  );

  // Protected writes pass only while unlocked.
  assign wr_open = wr_act && !lock_q;

  wpirq_intgroup #(.NUM_SRC(NUM_SRC)) u_group (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_clr_en (wr_open && (sel == SEL_STAT)),
    .stat_set_en (wr_open && (sel == SEL_TRIG)),
    .mask_clr_en (wr_open && (sel == SEL_ENA)),
    .mask_set_en (wr_open && (sel == SEL_DIS)),
    .bits        (bus_wdata[NUM_SRC-1:0]),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .irq         (irq_o)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_open && (sel == SEL_CTRL)) begin
      ctrl_d = bus_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_LOCK: rd_word[0]            = lock_q;
      SEL_CTRL: rd_word[CTRL_W-1:0]   = ctrl_q;
      SEL_STAT: rd_word[NUM_SRC-1:0]  = status_q;
      SEL_MASK: rd_word[NUM_SRC-1:0]  = mask_q;
      default:  rd_word               = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_act) begin
      rdata_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/wpirq_regset_chk.sv
module wpirq_regset_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_SRC = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [1:0]         bus_size,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               irq_o,
  input logic               lock_q,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic               wr_word;
  logic               to_lock;
  logic               to_stat;
  logic               to_ena;
  logic               to_dis;
  logic               to_trig;
  logic [NUM_SRC-1:0] wbits;

  assign wr_word = bus_req && bus_we && (bus_size == 2'd2);
  assign to_lock = (bus_addr == ADDR_W'('h00));
  assign to_stat = (bus_addr == ADDR_W'('h08));
  assign to_ena  = (bus_addr == ADDR_W'('h10));
  assign to_dis  = (bus_addr == ADDR_W'('h14));
  assign to_trig = (bus_addr == ADDR_W'('h18));
  assign wbits   = bus_wdata[NUM_SRC-1:0];

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && lock_q && !to_lock) |=> ($stable(status_q) && $stable(mask_q)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && !lock_q && to_stat) |=> ((status_q & $past(wbits)) == '0));

  assert_mask_ports_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_word && !lock_q && (to_ena || to_dis)) |=> $stable(mask_q));

  assert_trigger_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && !lock_q && to_trig) |=> ((status_q & $past(wbits)) == $past(wbits)));

  assert_trigger_unmasked_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && !lock_q && to_trig && ((wbits & ~mask_q) != '0)) |=> irq_o);

  assert_no_pending_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_o);

  assert_narrow_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && (bus_size != 2'd2)) |=> (bus_rdata == 32'd0));

  assert_lock_writable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && to_lock) |=> (lock_q == $past(bus_wdata[0])));
endmodule

bind wpirq_regset wpirq_regset_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .lock_q    (lock_q),
  .status_q  (status_q),
  .mask_q    (mask_q)
);

// File: tb/wpirq_regset_bench.sv
module wpirq_regset_bench;
  localparam int unsigned ADDR_W = 16;

  logic              clk;
  logic              rst_n;
  logic              bus_req;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [0:0]        ctrl_o;
  logic              irq_o;

  int checks;
  int failures;
  bit done;

  wpirq_regset #(.ADDR_W(ADDR_W), .NUM_SRC(1), .CTRL_W(1)) u_wpirq_regset (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_o    (ctrl_o),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(16'h00, v); check("R1 lock after reset", v, 32'd1);
    rd(16'h0C, v); check("R1 mask after reset", v, 32'd1);
    rd(16'h08, v); check("R1 status after reset", v, 32'd0);
    rd(16'h04, v); check("R1 ctrl after reset", v, 32'd0);
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_locked_writes();
    logic [31:0] v;
    wr(16'h04, 32'd1);
    wr(16'h10, 32'd1);
    wr(16'h18, 32'd1);
    rd(16'h04, v); check("R2 ctrl held while locked", v, 32'd0);
    rd(16'h0C, v); check("R2 mask held while locked", v, 32'd1);
    rd(16'h08, v); check("R2 status held while locked", v, 32'd0);
    check("R2 irq low while locked", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    wr(16'h00, 32'd0);
    rd(16'h00, v); check("R9 lock cleared", v, 32'd0);
    wr(16'h04, 32'd1);
    rd(16'h04, v); check("R2 ctrl written when unlocked", v, 32'd1);
    check("R2 ctrl_o follows", {31'd0, ctrl_o}, 32'd1);
  endtask

  task automatic t_trigger_unmask();
    logic [31:0] v;
    wr(16'h18, 32'd1);
    check("R7 masked pending keeps irq low", {31'd0, irq_o}, 32'd0);
    rd(16'h08, v); check("R6 trigger sets status", v, 32'd1);
    rd(16'h18, v); check("R6 trigger reads zero", v, 32'd0);
    wr(16'h10, 32'd1);
    check("R7 irq high after unmask", {31'd0, irq_o}, 32'd1);
    rd(16'h0C, v); check("R5 mask cleared by enable port", v, 32'd0);
    rd(16'h10, v); check("R5 enable port reads zero", v, 32'd0);
    wr(16'h0C, 32'd1);
    rd(16'h0C, v); check("R4 direct mask write ignored", v, 32'd0);
  endtask

  task automatic t_relock_and_clear();
    logic [31:0] v;
    wr(16'h00, 32'd1);
    rd(16'h00, v); check("R9 lock set again", v, 32'd1);
    wr(16'h08, 32'd1);
    wr(16'h14, 32'd1);
    rd(16'h08, v); check("R2 W1C blocked while locked", v, 32'd1);
    rd(16'h0C, v); check("R2 mask-set blocked while locked", v, 32'd0);
    check("R2 irq stays high while locked", {31'd0, irq_o}, 32'd1);
    wr(16'h00, 32'd0);
    wr(16'h08, 32'd0);
    rd(16'h08, v); check("R3 zero write keeps status", v, 32'd1);
    wr(16'h08, 32'd1);
    rd(16'h08, v); check("R3 one write clears status", v, 32'd0);
    check("R7 irq low after clear", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_disable_port();
    logic [31:0] v;
    wr(16'h14, 32'd1);
    rd(16'h0C, v); check("R5 mask set by disable port", v, 32'd1);
    rd(16'h14, v); check("R5 disable port reads zero", v, 32'd0);
    wr(16'h18, 32'd1);
    check("R7 masked trigger keeps irq low", {31'd0, irq_o}, 32'd0);
    wr(16'h08, 32'd1);
  endtask

  task automatic t_unmapped_and_size();
    logic [31:0] v;
    rd(16'h1C, v); check("R8 unmapped read zero", v, 32'd0);
    rd(16'h02, v); check("R8 misaligned read zero", v, 32'd0);
    wr(16'h1C, 32'hFFFF_FFFF);
    wr(16'h18, 32'd1, 2'd0);
    rd(16'h08, v); check("R8 byte trigger dropped", v, 32'd0);
    wr(16'h00, 32'd1, 2'd1);
    rd(16'h00, v); check("R8 halfword lock write dropped", v, 32'd0);
    rd(16'h0C, v, 2'd0); check("R8 byte read returns zero", v, 32'd0);
    rd(16'h0C, v); check("R10 word read after byte read", v, 32'd1);
    @(negedge clk);
    check("R10 read data held", bus_rdata, 32'd1);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_locked_writes();
    t_unlock();
    t_trigger_unmask();
    t_relock_and_clear();
    t_disable_port();
    t_unmapped_and_size();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule